// File: doc/BRIEF.md
# 64b/66b Block Decoder to XGMII Lanes

This block sits on the receive side of a 10 Gb/s physical coding layer, after block alignment. Each enabled clock it takes one 66-bit block: a 2-bit sync header and a 64-bit payload. If the build asks for it, the bit order of the block is undone first. The payload then passes through a self-synchronising descrambler. The block decoder turns the result into an eight-lane word with one data byte and one control flag per lane, in the layout a media-independent MAC interface expects.

Data blocks pass through unchanged. Control blocks are decoded by their type byte. The decoder rebuilds the Start and Terminate lanes, converts the packed 7-bit control codes into 8-bit lane characters, and expands the 4-bit ordered-set codes. A malformed block gives an output word made only of Error characters.

The result is registered, so it appears one clock after the block that was presented. An input valid qualifies every cycle. Block lock, bit slip and link-fault handling are done outside this block.

Top module: `blk66_decoder`

## Requirements
- R1: The decoded word and `out_valid` are registered. A block presented with `in_valid` high at a rising edge appears on `out_data`/`out_ctrl` just after that edge, with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low one cycle later.
- R2: While `in_valid` is low, `out_data` and `out_ctrl` keep their last values and the descrambler state does not advance. The next valid block therefore decodes as if the idle cycles had not happened.
- R3: The descrambler implements 1 + x^39 + x^58 (feedback taps 38 and 57 of a 58-bit history, payload bit 0 first). It shifts the received scrambled bits into its history. The history is zero after reset, and the sync header is never scrambled.
- R4: Sync header 2'b10 marks a data block. Lane i carries payload bits [8i+7:8i] and every control flag is 0. Lane i is `out_data[8i+7:8i]` with flag `out_ctrl[i]`.
- R5: Sync header 2'b01 marks a control block. The other header values, 2'b00 and 2'b11, give all eight lanes 0xFE with all flags set.
- R6: In a control block the type is payload byte 0. A type outside the fifteen listed in R7 to R10 gives all eight lanes 0xFE with all flags set.
- R7: Type 0x1E gives eight control lanes. Lane i is decoded from the 7-bit field at payload bits [14+7i:8+7i]. The code mapping is 0x00→0x07, 0x06→0x06, 0x1E→0xFE, 0x2D→0x1C, 0x33→0x3C, 0x4B→0x7C, 0x55→0xBC, 0x66→0xDC and 0x78→0xF7. Any other code becomes 0xFE.
- R8: Type 0x78 gives Start (0xFB) in lane 0 and payload bytes 1..7 as data in lanes 1..7. Type 0x33 gives control lanes 0..3 (fields as in R7), Start in lane 4, and data bytes 5..7 in lanes 5..7.
- R9: Ordered sets take their code from payload byte 4: the low nibble for lane 0 and the high nibble for lane 4. Code 0x0 becomes 0x9C, 0xF becomes 0x5C, and any other value becomes 0xFE. The ordered-set block types are as follows. 0x4B has an ordered set in lane 0, data bytes 1..3, and control lanes 4..7. 0x2D has control lanes 0..3, an ordered set in lane 4, and data 5..7. 0x66 has an ordered set in lane 0, data 1..3, Start in lane 4, and data 5..7. 0x55 has ordered sets in lanes 0 and 4 and data in the other lanes.
- R10: Types 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 and 0xFF terminate in lane k = 0..7 respectively. Lanes 0..k-1 carry payload bytes 1..k as data. Lane k carries Terminate (0xFD). Lanes k+1..7 carry control characters decoded from their R7 fields.
- R11: During and straight after reset, `out_valid` is 0 and every lane holds Idle (0x07) with its control flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Qualifies the block on `in_hdr`/`in_blk` this cycle |
| in_hdr | input | 2 | Sync header of the block |
| in_blk | input | 64 | Scrambled block payload |
| out_valid | output | 1 | Decoded word on the outputs is new this cycle |
| out_data | output | 64 | Eight lane characters, lane i in bits [8i+7:8i] |
| out_ctrl | output | 8 | Control flag per lane, lane i in bit i |

## Verification
Every result is due exactly one rising edge after the block is sampled. The bench drives each block on a falling edge and reads the outputs on the next falling edge, which is half a period after the register has loaded. The expected word is computed when the block is driven, so the comparison has no latency offset. Idle cycles are read on the same schedule and must show the held word with `out_valid` low. Descrambler continuity across those gaps is then proven by the next valid block, whose expected value comes from a bench scrambler that did not advance during the gap.

// File: rtl/blk66_pkg.sv
package blk66_pkg;

  localparam int LANES   = 8;
  localparam int BYTE_W  = 8;
  localparam int DATA_W  = LANES * BYTE_W;
  localparam int CODE_W  = 7;
  localparam int OCODE_W = 4;

  localparam logic [1:0] HDR_DATA = 2'b10;
  localparam logic [1:0] HDR_CTRL = 2'b01;

  localparam logic [7:0] LC_IDLE  = 8'h07;
  localparam logic [7:0] LC_LPI   = 8'h06;
  localparam logic [7:0] LC_START = 8'hFB;
  localparam logic [7:0] LC_TERM  = 8'hFD;
  localparam logic [7:0] LC_ERR   = 8'hFE;
  localparam logic [7:0] LC_SEQ   = 8'h9C;
  localparam logic [7:0] LC_SIG   = 8'h5C;
  localparam logic [7:0] LC_RSV0  = 8'h1C;
  localparam logic [7:0] LC_RSV1  = 8'h3C;
  localparam logic [7:0] LC_RSV2  = 8'h7C;
  localparam logic [7:0] LC_RSV3  = 8'hBC;
  localparam logic [7:0] LC_RSV4  = 8'hDC;
  localparam logic [7:0] LC_RSV5  = 8'hF7;

  typedef enum logic [7:0] {
    BT_ALLCTL  = 8'h1E,
    BT_OS_HI   = 8'h2D,
    BT_ST_HI   = 8'h33,
    BT_OS_ST   = 8'h66,
    BT_OS_BOTH = 8'h55,
    BT_ST_LO   = 8'h78,
    BT_OS_LO   = 8'h4B,
    BT_END0    = 8'h87,
    BT_END1    = 8'h99,
    BT_END2    = 8'hAA,
    BT_END3    = 8'hB4,
    BT_END4    = 8'hCC,
    BT_END5    = 8'hD2,
    BT_END6    = 8'hE1,
    BT_END7    = 8'hFF
  } blk_type_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [LANES-1:0]  ctrl;
  } lane_word_t;

  function automatic logic [7:0] oset_char(input logic [OCODE_W-1:0] oc);
    logic [7:0] r;
    case (oc)
      4'h0:    r = LC_SEQ;
      4'hF:    r = LC_SIG;
      default: r = LC_ERR;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/blk66_code_map.sv
module blk66_code_map
  import blk66_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [7:0]        lane_char
);

  always_comb begin
    case (code)
      7'h00:   lane_char = LC_IDLE;
      7'h06:   lane_char = LC_LPI;
      7'h1E:   lane_char = LC_ERR;
      7'h2D:   lane_char = LC_RSV0;
      7'h33:   lane_char = LC_RSV1;
      7'h4B:   lane_char = LC_RSV2;
      7'h55:   lane_char = LC_RSV3;
      7'h66:   lane_char = LC_RSV4;
      7'h78:   lane_char = LC_RSV5;
      default: lane_char = LC_ERR;
    endcase
  end

endmodule

// File: rtl/blk66_descrambler.sv
module blk66_descrambler #(
  parameter int W      = 64,
  parameter int SCR_W  = 58,
  parameter int TAP_A  = 38,
  parameter int TAP_B  = 57,
  parameter bit ENABLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int EXT_W = SCR_W + W;
  localparam int OFS_A = SCR_W - TAP_A - 1;
  localparam int OFS_B = SCR_W - TAP_B - 1;

  logic [SCR_W-1:0] hist_q;
  logic [SCR_W-1:0] hist_d;
  logic [SCR_W-1:0] hist_nxt;
  logic [EXT_W-1:0] ext;
  logic [W-1:0]     clear_bits;

  // ext[0] is the oldest remembered bit, ext[EXT_W-1] the newest received bit
  for (genvar g = 0; g < SCR_W; g++) begin : g_hist
    assign ext[g] = hist_q[SCR_W-1-g];
  end
  assign ext[EXT_W-1:SCR_W] = din;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign clear_bits[g] = din[g] ^ ext[g + SCR_W + OFS_A - SCR_W + SCR_W - SCR_W + 0 + 0]
                                  ^ ext[g + SCR_W + OFS_B - SCR_W];
  end

  for (genvar g = 0; g < SCR_W; g++) begin : g_nxt
    assign hist_nxt[g] = din[W-1-g];
  end

  always_comb begin
    hist_d = hist_q;
    if (adv) hist_d = hist_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  if (ENABLE) begin : g_scr_on
    assign dout = clear_bits;
  end else begin : g_scr_off
    assign dout = din;
  end

endmodule

// File: rtl/blk66_lane_decoder.sv
module blk66_lane_decoder
  import blk66_pkg::*;
(
  input  logic [1:0]        hdr,
  input  logic [DATA_W-1:0] pay,
  output lane_word_t        word
);

  logic [LANES-1:0][7:0] ctl_char;
  logic [LANES-1:0][7:0] pay_byte;
  logic [LANES-1:0][7:0] lane;
  logic [LANES-1:0]      flag;
  logic [7:0]            oset_lo;
  logic [7:0]            oset_hi;
  logic [3:0]            end_lane;
  logic                  is_end;
  blk_type_e             btype;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign pay_byte[i] = pay[BYTE_W*i +: BYTE_W];
    blk66_code_map u_map (
      .code      (pay[BYTE_W + CODE_W*i +: CODE_W]),
      .lane_char (ctl_char[i])
    );
  end

  assign btype   = blk_type_e'(pay_byte[0]);
  assign oset_lo = oset_char(pay_byte[4][3:0]);
  assign oset_hi = oset_char(pay_byte[4][7:4]);

  always_comb begin
    is_end   = 1'b1;
    end_lane = 4'd0;
    case (btype)
      BT_END0: end_lane = 4'd0;
      BT_END1: end_lane = 4'd1;
      BT_END2: end_lane = 4'd2;
      BT_END3: end_lane = 4'd3;
      BT_END4: end_lane = 4'd4;
      BT_END5: end_lane = 4'd5;
      BT_END6: end_lane = 4'd6;
      BT_END7: end_lane = 4'd7;
      default: is_end = 1'b0;
    endcase
  end

  always_comb begin
    lane = pay_byte;
    flag = '0;
    if (hdr == HDR_DATA) begin
      lane = pay_byte;
      flag = '0;
    end else if (hdr != HDR_CTRL) begin
      lane = {LANES{LC_ERR}};
      flag = '1;
    end else if (is_end) begin
      for (int i = 0; i < LANES; i++) begin
        if (i < int'(end_lane)) begin
          lane[i] = pay_byte[i+1];
          flag[i] = 1'b0;
        end else if (i == int'(end_lane)) begin
          lane[i] = LC_TERM;
          flag[i] = 1'b1;
        end else begin
          lane[i] = ctl_char[i];
          flag[i] = 1'b1;
        end
      end
    end else begin
      case (btype)
        BT_ALLCTL: begin
          lane = ctl_char;
          flag = '1;
        end
        BT_ST_LO: begin
          lane[0] = LC_START;
          flag    = 8'h01;
        end
        BT_ST_HI: begin
          lane[3:0] = ctl_char[3:0];
          lane[4]   = LC_START;
          flag      = 8'h1F;
        end
        BT_OS_LO: begin
          lane[0]   = oset_lo;
          lane[7:4] = ctl_char[7:4];
          flag      = 8'hF1;
        end
        BT_OS_HI: begin
          lane[3:0] = ctl_char[3:0];
          lane[4]   = oset_hi;
          flag      = 8'h1F;
        end
        BT_OS_ST: begin
          lane[0] = oset_lo;
          lane[4] = LC_START;
          flag    = 8'h11;
        end
        BT_OS_BOTH: begin
          lane[0] = oset_lo;
          lane[4] = oset_hi;
          flag    = 8'h11;
        end
        default: begin
          lane = {LANES{LC_ERR}};
          flag = '1;
        end
      endcase
    end
  end

  assign word.data = lane;
  assign word.ctrl = flag;

endmodule

// File: rtl/blk66_decoder.sv
module blk66_decoder
  import blk66_pkg::*;
#(
  parameter int SCR_W    = 58,
  parameter int TAP_A    = 38,
  parameter int TAP_B    = 57,
  parameter bit SCRAMBLE = 1'b1,
  parameter bit BIT_REV  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_hdr,
  input  logic [DATA_W-1:0] in_blk,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [LANES-1:0]  out_ctrl
);

  logic [1:0]        hdr_ord;
  logic [DATA_W-1:0] blk_ord;
  logic [DATA_W-1:0] blk_clear;
  lane_word_t        dec_word;
  lane_word_t        word_q;
  lane_word_t        word_d;
  logic              vld_q;
  logic              vld_d;

  if (BIT_REV) begin : g_rev
    for (genvar i = 0; i < DATA_W; i++) begin : g_b
      assign blk_ord[i] = in_blk[DATA_W-1-i];
    end
    assign hdr_ord = {in_hdr[0], in_hdr[1]};
  end else begin : g_fwd
    assign blk_ord = in_blk;
    assign hdr_ord = in_hdr;
  end

  blk66_descrambler #(
    .W      (DATA_W),
    .SCR_W  (SCR_W),
    .TAP_A  (TAP_A),
    .TAP_B  (TAP_B),
    .ENABLE (SCRAMBLE)
  ) u_descr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (in_valid),
    .din   (blk_ord),
    .dout  (blk_clear)
  );

  blk66_lane_decoder u_dec (
    .hdr  (hdr_ord),
    .pay  (blk_clear),
    .word (dec_word)
  );

  always_comb begin
    word_d = word_q;
    vld_d  = in_valid;
    if (in_valid) word_d = dec_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q       <= 1'b0;
      word_q.data <= {LANES{LC_IDLE}};
      word_q.ctrl <= '1;
    end else begin
      vld_q  <= vld_d;
      word_q <= word_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = word_q.data;
  assign out_ctrl  = word_q.ctrl;

endmodule

// File: rtl/blk66_decoder_chk.sv
module blk66_decoder_chk #(
  parameter bit BIT_REV = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  in_hdr,
  input logic        out_valid,
  input logic [63:0] out_data,
  input logic [7:0]  out_ctrl
);

  logic [1:0] hdr_seen;
  assign hdr_seen = BIT_REV ? {in_hdr[0], in_hdr[1]} : in_hdr;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_ctrl)));

  assert_data_flags_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hdr_seen == 2'b10) |=> (out_ctrl == 8'h00));

  assert_bad_header_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_hdr == 2'b00 || in_hdr == 2'b11))
      |=> (out_ctrl == 8'hFF && out_data == {8{8'hFE}}));

  assert_ctrl_block_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hdr_seen == 2'b01) |=> (out_ctrl != 8'h00));

endmodule

bind blk66_decoder blk66_decoder_chk #(.BIT_REV(BIT_REV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_hdr    (in_hdr),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ctrl  (out_ctrl)
);

// File: tb/blk66_decoder_bench.sv
module blk66_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_hdr;
  logic [63:0] in_blk;
  logic        out_valid;
  logic [63:0] out_data;
  logic [7:0]  out_ctrl;

  int n_checks;
  int n_fail;
  logic [57:0] scr_st;

  blk66_decoder u_blk66_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_hdr    (in_hdr),
    .in_blk    (in_blk),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ctrl  (out_ctrl)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // code table from R7
  function automatic logic [7:0] m_code(input logic [6:0] c);
    case (c)
      7'h00: return 8'h07;
      7'h06: return 8'h06;
      7'h1E: return 8'hFE;
      7'h2D: return 8'h1C;
      7'h33: return 8'h3C;
      7'h4B: return 8'h7C;
      7'h55: return 8'hBC;
      7'h66: return 8'hDC;
      7'h78: return 8'hF7;
      default: return 8'hFE;
    endcase
  endfunction

  // ordered-set codes from R9
  function automatic logic [7:0] m_os(input logic [3:0] o);
    if (o == 4'h0) return 8'h9C;
    if (o == 4'hF) return 8'h5C;
    return 8'hFE;
  endfunction

  // expected {lanes, flags} for an unscrambled block (R4..R10)
  function automatic logic [71:0] m_decode(input logic [1:0] h, input logic [63:0] p);
    logic [7:0] L [8];
    logic [7:0] C;
    int t;
    for (int i = 0; i < 8; i++) L[i] = p[8*i +: 8];
    C = 8'h00;
    t = -1;
    if (h == 2'b10) begin
      C = 8'h00;
    end else if (h != 2'b01) begin
      for (int i = 0; i < 8; i++) L[i] = 8'hFE;
      C = 8'hFF;
    end else begin
      case (p[7:0])
        8'h87: t = 0;
        8'h99: t = 1;
        8'hAA: t = 2;
        8'hB4: t = 3;
        8'hCC: t = 4;
        8'hD2: t = 5;
        8'hE1: t = 6;
        8'hFF: t = 7;
        default: t = -1;
      endcase
      if (t >= 0) begin
        for (int i = 0; i < 8; i++) begin
          if (i < t) L[i] = p[8*(i+1) +: 8];
          else if (i == t) L[i] = 8'hFD;
          else L[i] = m_code(p[8+7*i +: 7]);
          C[i] = (i >= t);
        end
      end else begin
        case (p[7:0])
          8'h1E: begin
            for (int i = 0; i < 8; i++) L[i] = m_code(p[8+7*i +: 7]);
            C = 8'hFF;
          end
          8'h78: begin L[0] = 8'hFB; C = 8'h01; end
          8'h33: begin
            for (int i = 0; i < 4; i++) L[i] = m_code(p[8+7*i +: 7]);
            L[4] = 8'hFB; C = 8'h1F;
          end
          8'h4B: begin
            L[0] = m_os(p[35:32]);
            for (int i = 4; i < 8; i++) L[i] = m_code(p[8+7*i +: 7]);
            C = 8'hF1;
          end
          8'h2D: begin
            for (int i = 0; i < 4; i++) L[i] = m_code(p[8+7*i +: 7]);
            L[4] = m_os(p[39:36]); C = 8'h1F;
          end
          8'h66: begin L[0] = m_os(p[35:32]); L[4] = 8'hFB; C = 8'h11; end
          8'h55: begin L[0] = m_os(p[35:32]); L[4] = m_os(p[39:36]); C = 8'h11; end
          default: begin
            for (int i = 0; i < 8; i++) L[i] = 8'hFE;
            C = 8'hFF;
          end
        endcase
      end
    end
    return {L[7], L[6], L[5], L[4], L[3], L[2], L[1], L[0], C};
  endfunction

  // serial scrambler, bit 0 first, output bit fed back (pairs with R3)
  function automatic logic [63:0] scramble(input logic [63:0] p);
    logic [63:0] o;
    for (int i = 0; i < 64; i++) begin
      o[i]   = p[i] ^ scr_st[38] ^ scr_st[57];
      scr_st = {scr_st[56:0], o[i]};
    end
    return o;
  endfunction

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual data=%h ctrl=%h expected data=%h ctrl=%h",
               req, act[71:8], act[7:0], exp[71:8], exp[7:0]);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // drive at a falling edge, read at the next falling edge (one register, R1)
  task automatic send(input string req, input logic [1:0] h, input logic [63:0] plain);
    logic [71:0] exp;
    exp      = m_decode(h, plain);
    in_valid = 1'b1;
    in_hdr   = h;
    in_blk   = scramble(plain);
    @(negedge clk);
    check_bit({req, " valid R1"}, out_valid, 1'b1);
    check(req, {out_data, out_ctrl}, exp);
  endtask

  task automatic idle_cycle(input string req);
    logic [71:0] held;
    held     = {out_data, out_ctrl};
    in_valid = 1'b0;
    in_hdr   = 2'(($urandom) & 3);
    in_blk   = {$urandom, $urandom};
    @(negedge clk);
    check_bit({req, " valid low R1"}, out_valid, 1'b0);
    check(req, {out_data, out_ctrl}, held);
  endtask

  function automatic logic [6:0] good_code(input int sel);
    case (sel % 9)
      0: return 7'h00;
      1: return 7'h06;
      2: return 7'h1E;
      3: return 7'h2D;
      4: return 7'h33;
      5: return 7'h4B;
      6: return 7'h55;
      7: return 7'h66;
      default: return 7'h78;
    endcase
  endfunction

  function automatic logic [63:0] ctrl_block(input logic [7:0] bt, input logic [3:0] olo,
                                             input logic [3:0] ohi);
    logic [63:0] p;
    p = {$urandom, $urandom};
    for (int i = 0; i < 8; i++) p[8+7*i +: 7] = good_code(int'($urandom % 9));
    p[7:0]   = bt;
    p[35:32] = olo;
    p[39:36] = ohi;
    return p;
  endfunction

  logic done;
  initial begin
    done = 1'b0;
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] types [15];
    logic [63:0] p;
    void'($urandom(32'h1F2E3D4C));
    n_checks = 0;
    n_fail   = 0;
    scr_st   = '0;
    types = '{8'h1E, 8'h2D, 8'h33, 8'h66, 8'h55, 8'h78, 8'h4B, 8'h87,
              8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_hdr   = 2'b00;
    in_blk   = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check_bit("R11 valid in reset", out_valid, 1'b0);
    check("R11 idle in reset", {out_data, out_ctrl}, {{8{8'h07}}, 8'hFF});
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", {out_data, out_ctrl}, {{8{8'h07}}, 8'hFF});

    // directed: data, headers, types
    send("R4 data block", 2'b10, 64'h0123_4567_89AB_CDEF);
    send("R3 zero payload data", 2'b10, 64'h0);
    send("R5 header 00", 2'b00, 64'h1E);
    send("R5 header 11", 2'b11, 64'h78);
    send("R6 unknown type", 2'b01, 64'hDEAD_BEEF_0000_0000);
    send("R7 all idle", 2'b01, 64'h1E);
    p = 64'h1E;
    p[8 +: 7] = 7'h11;
    send("R7 unknown code", 2'b01, p);
    send("R7 all control mix", 2'b01, ctrl_block(8'h1E, 4'h0, 4'h0));
    send("R8 start lane 0", 2'b01, ctrl_block(8'h78, 4'h3, 4'h9));
    send("R8 start lane 4", 2'b01, ctrl_block(8'h33, 4'h0, 4'h0));
    send("R9 oset lane 0 seq", 2'b01, ctrl_block(8'h4B, 4'h0, 4'h2));
    send("R9 oset lane 0 sig", 2'b01, ctrl_block(8'h4B, 4'hF, 4'h2));
    send("R9 oset lane 4 sig", 2'b01, ctrl_block(8'h2D, 4'h1, 4'hF));
    send("R9 oset bad code", 2'b01, ctrl_block(8'h2D, 4'h1, 4'h5));
    send("R9 oset and start", 2'b01, ctrl_block(8'h66, 4'hF, 4'h0));
    send("R9 two osets", 2'b01, ctrl_block(8'h55, 4'h0, 4'hF));
    for (int k = 0; k < 8; k++)
      send($sformatf("R10 terminate lane %0d", k), 2'b01, ctrl_block(types[7+k], 4'h0, 4'h0));

    // R2: gap of idle cycles, then continuity of descrambling
    idle_cycle("R2 hold 1");
    idle_cycle("R2 hold 2");
    idle_cycle("R2 hold 3");
    send("R2 R3 resume after gap", 2'b10, {$urandom, $urandom});

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = int'($urandom % 20);
      if (sel < 4) begin
        send("R4 R3 random data", 2'b10, {$urandom, $urandom});
      end else if (sel < 17) begin
        send("R7 R8 R9 R10 random control", 2'b01,
             ctrl_block(types[$urandom % 15], 4'($urandom), 4'($urandom)));
      end else if (sel < 18) begin
        send("R5 R6 random malformed", 2'(($urandom % 2) * 3), {$urandom, $urandom});
      end else begin
        idle_cycle("R2 random idle");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule